// File: doc/BRIEF.md
# Nine-Level Inverter Gate Pattern Generator

This block produces the nine gate drive lines of a single-phase switched-capacitor boost inverter with nine power switches and a nine-step output (-4 to +4 times the input voltage). A phase accumulator advances by a tuning word once per carrier sample. Its upper half-cycle bits feed a parabolic half-sine approximation, and the result is scaled by an 8-bit modulation index. The sign of the waveform comes from the accumulator's top bit, and the magnitude is compared against four stacked parabolic carriers. The number of carriers the magnitude exceeds gives the target level.

A registered level moves toward that target by at most one step per carrier sample. The level is then decoded into a fixed switch pattern. Zero has two patterns, and the one used depends on the current half-cycle. Each gate line has its own turn-on delay counter, and turn-off takes effect on the next clock. Dropping the enable or asserting reset clears every gate and returns the level to zero.

Top module: `ninelvl_gate_gen`

## Requirements
- R1: While rst_n is low, every gate_o bit is 0 and level_o is 0. A clock edge that samples en low clears gate_o to 0, clears level_o to 0, and restarts the phase, carrier and sample counters.
- R2: level_o is a 4-bit two's complement code that only takes the values -4 to +4. With the modulation index at 255, both +4 and -4 appear within one fundamental period.
- R3: The reference magnitude is min(4095, x*(4096-x)/1024), where x is accumulator bits [PHASE_W-2 -: 12]. It is scaled by mod_idx/256, and accumulator bit PHASE_W-1 set means the negative half-cycle. With mod_idx 154 the largest level reached is 3.
- R4: Carrier k (k = 0..3) is k*1024 + p*2^(10-TRI_W), where p = v*v/2^TRI_W and v is a triangular count rising 0..2^TRI_W-1 and then falling back. The target magnitude is the number of carriers strictly below the reference magnitude.
- R5: A sample strobe occurs every CAR_DIV clocks while enabled. On that strobe the accumulator advances by tune, the carrier count advances by one, and level_o moves one step toward the signed target. level_o never changes at any other time while enabled.
- R6: The demanded gates (gate_o bit i = switch S(i+1)) are: +4 = S2,S6,S8; +3 = S3,S4,S6,S8; +2 = S2,S5,S7,S8; +1 = S3,S4,S8; -1 = S3,S4,S9; -2 = S1,S5,S6,S9; -3 = S3,S4,S7,S9; -4 = S1,S7,S9.
- R7: At level 0 the demand is S1,S5,S8 when the half-cycle sign captured at the last strobe is positive (also after reset), and S2,S5,S9 when it is negative.
- R8: A gate rises only after its demand has been high at DEAD_CYC consecutive clock edges. It falls at the first clock edge that samples its demand low.
- R9: gate_o bits 7 (S8) and 8 (S9) are never 1 together.
- R10: With mod_idx 0 the level settles at 0 and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces all gates off and level 0 |
| mod_idx | input | MI_W | Modulation index, value/256 of full scale |
| tune | input | PHASE_W | Phase increment applied per carrier sample |
| gate_o | output | 9 | Gate lines, bit i drives switch S(i+1) |
| level_o | output | 4 | Current signed level code |

## Verification
The level stepper and the per-gate dead-time counters can act on the same clock edge. A strobe may change the level in the very cycle a gate's delay expires. When two adjacent levels share a gate, that gate must keep its count and stay on, while the gates that are only demanded by the new level start counting from zero. The bench provokes this with a slow carrier divider beside a short delay, and with a large tuning word that makes the target run far ahead of the one-step level. It compares the gates and the level against its own behavioural model every clock.

// File: rtl/ngg_pkg.sv
package ngg_pkg;
  localparam int REF_W   = 12;
  localparam int GATES   = 9;
  localparam int LVL_W   = 4;
  localparam int BANDS   = 4;
  localparam int TGT_W   = 3;

  typedef logic [REF_W-1:0]        ref_t;
  typedef logic signed [LVL_W-1:0] lvl_t;
  typedef logic [GATES-1:0]        gate_t;

  // Parabolic half-sine: x*(2^REF_W - x) / 2^(REF_W-2), saturated to full scale
  function automatic ref_t half_sine(input ref_t x);
    logic [REF_W:0]     cx;
    logic [2*REF_W-1:0] prod;
    logic [2*REF_W-1:0] sh;
    cx   = (REF_W+1)'(1 << REF_W) - {1'b0, x};
    prod = {{REF_W{1'b0}}, x} * {{(REF_W-1){1'b0}}, cx};
    sh   = prod >> (REF_W-2);
    if (sh > {{REF_W{1'b0}}, {REF_W{1'b1}}}) return {REF_W{1'b1}};
    return sh[REF_W-1:0];
  endfunction

  // Switch demand for a level; bit i is switch S(i+1)
  function automatic gate_t level_gates(input lvl_t lv, input logic neg);
    gate_t g;
    case (lv)
      4'b0100: g = 9'b010100010;
      4'b0011: g = 9'b010101100;
      4'b0010: g = 9'b011010010;
      4'b0001: g = 9'b010001100;
      4'b1111: g = 9'b100001100;
      4'b1110: g = 9'b100110001;
      4'b1101: g = 9'b101001100;
      4'b1100: g = 9'b101000001;
      default: g = neg ? 9'b100010010 : 9'b010010001;
    endcase
    return g;
  endfunction

  function automatic lvl_t step_toward(input lvl_t cur, input lvl_t tgt);
    if (tgt > cur) return cur + lvl_t'(1);
    if (tgt < cur) return cur - lvl_t'(1);
    return cur;
  endfunction
endpackage

// File: rtl/ngg_ref_gen.sv
module ngg_ref_gen
  import ngg_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int MI_W    = 8,
  parameter int CAR_DIV = 78
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PHASE_W-1:0] tune,
  input  logic [MI_W-1:0]    mod_idx,
  output logic               smp_stb,
  output ref_t               ref_mag,
  output logic               ref_neg
);
  localparam int PRE_W = (CAR_DIV > 1) ? $clog2(CAR_DIV) : 1;

  logic [PRE_W-1:0]        pre_q;
  logic [PHASE_W-1:0]      phase_q;
  ref_t                    sine_mag;
  logic [REF_W+MI_W-1:0]   scaled;

  assign smp_stb = en && (pre_q == PRE_W'(CAR_DIV-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      phase_q <= '0;
    end else if (!en) begin
      pre_q   <= '0;
      phase_q <= '0;
    end else if (smp_stb) begin
      pre_q   <= '0;
      phase_q <= phase_q + tune;
    end else begin
      pre_q   <= pre_q + PRE_W'(1);
    end
  end

  assign sine_mag = half_sine(phase_q[PHASE_W-2 -: REF_W]);
  assign scaled   = {{MI_W{1'b0}}, sine_mag} * {{REF_W{1'b0}}, mod_idx};
  assign ref_mag  = scaled[REF_W+MI_W-1:MI_W];
  assign ref_neg  = phase_q[PHASE_W-1];
endmodule

// File: rtl/ngg_carrier_bank.sv
module ngg_carrier_bank
  import ngg_pkg::*;
#(
  parameter int TRI_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             smp_stb,
  input  ref_t             ref_mag,
  output logic [TGT_W-1:0] tgt_mag
);
  localparam int SH = REF_W - 2 - TRI_W;

  logic [TRI_W:0]     cnt_q;
  logic [TRI_W-1:0]   tri_v;
  logic [2*TRI_W-1:0] sq;
  logic [TRI_W-1:0]   para;
  logic [BANDS-1:0]   above;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en)     cnt_q <= '0;
    else if (smp_stb) cnt_q <= cnt_q + (TRI_W+1)'(1);
  end

  assign tri_v = cnt_q[TRI_W] ? ~cnt_q[TRI_W-1:0] : cnt_q[TRI_W-1:0];
  assign sq    = {{TRI_W{1'b0}}, tri_v} * {{TRI_W{1'b0}}, tri_v};
  assign para  = sq[2*TRI_W-1:TRI_W];

  for (genvar k = 0; k < BANDS; k++) begin : g_band
    ref_t carrier;
    assign carrier  = (ref_t'(k) << (REF_W-2)) | (ref_t'(para) << SH);
    assign above[k] = ref_mag > carrier;
  end

  always_comb begin
    tgt_mag = '0;
    for (int k = 0; k < BANDS; k++) tgt_mag = tgt_mag + TGT_W'(above[k]);
  end
endmodule

// File: rtl/ngg_level_seq.sv
module ngg_level_seq
  import ngg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             smp_stb,
  input  logic [TGT_W-1:0] tgt_mag,
  input  logic             ref_neg,
  output lvl_t             lvl,
  output logic             pol_neg
);
  lvl_t tmag;
  lvl_t tgt;

  assign tmag = lvl_t'({1'b0, tgt_mag});
  assign tgt  = ref_neg ? -tmag : tmag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= '0;
      pol_neg <= 1'b0;
    end else if (!en) begin
      lvl     <= '0;
      pol_neg <= 1'b0;
    end else if (smp_stb) begin
      lvl     <= step_toward(lvl, tgt);
      pol_neg <= ref_neg;
    end
  end
endmodule

// File: rtl/ngg_dead_time.sv
module ngg_dead_time
  import ngg_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  gate_t want,
  output gate_t gate
);
  localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;

  for (genvar i = 0; i < GATES; i++) begin : g_line
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q   <= '0;
        gate[i] <= 1'b0;
      end else if (!want[i]) begin
        cnt_q   <= '0;
        gate[i] <= 1'b0;
      end else if (!gate[i]) begin
        if (cnt_q == CW'(DEAD_CYC-1)) gate[i] <= 1'b1;
        else                          cnt_q   <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/ninelvl_gate_gen.sv
module ninelvl_gate_gen
  import ngg_pkg::*;
#(
  parameter int PHASE_W  = 16,
  parameter int MI_W     = 8,
  parameter int TRI_W    = 8,
  parameter int CAR_DIV  = 78,
  parameter int DEAD_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [MI_W-1:0]    mod_idx,
  input  logic [PHASE_W-1:0] tune,
  output logic [GATES-1:0]   gate_o,
  output logic [LVL_W-1:0]   level_o
);
  logic             smp_stb;
  ref_t             ref_mag;
  logic             ref_neg;
  logic [TGT_W-1:0] tgt_mag;
  lvl_t             lvl;
  logic             pol_neg;
  gate_t            gate_want;
  gate_t            gate_q;

  ngg_ref_gen #(.PHASE_W(PHASE_W), .MI_W(MI_W), .CAR_DIV(CAR_DIV)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(en), .tune(tune), .mod_idx(mod_idx),
    .smp_stb(smp_stb), .ref_mag(ref_mag), .ref_neg(ref_neg)
  );

  ngg_carrier_bank #(.TRI_W(TRI_W)) u_car (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_stb(smp_stb),
    .ref_mag(ref_mag), .tgt_mag(tgt_mag)
  );

  ngg_level_seq u_lvl (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_stb(smp_stb),
    .tgt_mag(tgt_mag), .ref_neg(ref_neg), .lvl(lvl), .pol_neg(pol_neg)
  );

  assign gate_want = en ? level_gates(lvl, pol_neg) : '0;

  ngg_dead_time #(.DEAD_CYC(DEAD_CYC)) u_dt (
    .clk(clk), .rst_n(rst_n), .want(gate_want), .gate(gate_q)
  );

  assign gate_o  = gate_q;
  assign level_o = lvl;
endmodule

// File: rtl/ngg_checker.sv
module ngg_checker
  import ngg_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             smp_stb,
  input logic [GATES-1:0] gate_want,
  input logic [GATES-1:0] gate_o,
  input logic [LVL_W-1:0] level_o
);
  localparam int CW = $clog2(DEAD_CYC + 2);

  logic signed [LVL_W:0] prev_lvl;
  logic signed [LVL_W:0] cur_lvl;
  logic signed [LVL_W:0] lvl_diff;

  assign cur_lvl  = {level_o[LVL_W-1], level_o};
  assign lvl_diff = cur_lvl - prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= '0;
    else        prev_lvl <= cur_lvl;
  end

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate_o == '0 && level_o == '0)); // R1
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lvl >= -5'sd4 && cur_lvl <= 5'sd4); // R2
  AST_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && lvl_diff != 0) |-> ($past(smp_stb) && (lvl_diff == 1 || lvl_diff == -1))); // R5
  AST_POLARITY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[7] && gate_o[8])); // R9

  for (genvar i = 0; i < GATES; i++) begin : g_chk
    logic [CW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run_q <= '0;
      else if (!gate_want[i]) run_q <= '0;
      else if (run_q < CW'(DEAD_CYC)) run_q <= run_q + CW'(1);
    end
    AST_DEAD_BEFORE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o[i]) |-> run_q >= CW'(DEAD_CYC)); // R8
    AST_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_want[i] |=> !gate_o[i]); // R8
  end
endmodule

bind ninelvl_gate_gen ngg_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .smp_stb(smp_stb),
  .gate_want(gate_want), .gate_o(gate_o), .level_o(level_o)
);

// File: tb/tb_ninelvl_gate_gen.sv
module tb_ninelvl_gate_gen;
  localparam int TRI_W = 6;
  localparam int CDIV  = 4;
  localparam int DEAD  = 3;
  localparam int TMAX  = 2 ** (TRI_W + 1);

  logic       clk = 0;
  logic       rst_n = 0;
  logic       en = 0;
  logic [7:0] mod_idx = 0;
  logic [15:0] tune = 0;
  logic [8:0] gate_o;
  logic [3:0] level_o;

  int checks = 0, errors = 0;
  bit done = 0;

  ninelvl_gate_gen #(.PHASE_W(16), .MI_W(8), .TRI_W(TRI_W), .CAR_DIV(CDIV), .DEAD_CYC(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mod_idx(mod_idx), .tune(tune),
    .gate_o(gate_o), .level_o(level_o)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  int m_phase, m_cnt, m_pre, m_lvl, m_neg;
  int run[9];
  logic [8:0] m_gate;

  function automatic logic [8:0] sw(input int a, input int b, input int c, input int d);
    logic [8:0] g = '0;
    if (a > 0) g[a-1] = 1'b1;
    if (b > 0) g[b-1] = 1'b1;
    if (c > 0) g[c-1] = 1'b1;
    if (d > 0) g[d-1] = 1'b1;
    return g;
  endfunction

  function automatic logic [8:0] demand(input int lv, input int neg);
    case (lv)
      4: return sw(2, 6, 8, 0);
      3: return sw(3, 4, 6, 8);
      2: return sw(2, 5, 7, 8);
      1: return sw(3, 4, 8, 0);
      -1: return sw(3, 4, 9, 0);
      -2: return sw(1, 5, 6, 9);
      -3: return sw(3, 4, 7, 9);
      -4: return sw(1, 7, 9, 0);
      default: return neg ? sw(2, 5, 9, 0) : sw(1, 5, 8, 0);
    endcase
  endfunction

  function automatic int target(input int ph, input int cn, input int mi);
    int x, m, r, v, p, n;
    x = (ph / 8) % 4096;
    m = x * (4096 - x) / 1024;
    if (m > 4095) m = 4095;
    r = m * mi / 256;
    v = (cn < TMAX / 2) ? cn : (TMAX - 1 - cn);
    p = v * v / (TMAX / 2);
    n = 0;
    for (int k = 0; k < 4; k++) if (r > 1024 * k + p * (1024 / (TMAX / 2))) n++;
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_pre = 0; m_lvl = 0; m_neg = 0; m_gate = '0;
      for (int k = 0; k < 9; k++) run[k] = 0;
    end else begin
      logic [8:0] d;
      d = en ? demand(m_lvl, m_neg) : 9'd0;
      for (int k = 0; k < 9; k++) begin
        run[k] = d[k] ? ((run[k] < 1000) ? run[k] + 1 : run[k]) : 0;
        m_gate[k] = (run[k] >= DEAD);
      end
      if (!en) begin
        m_phase = 0; m_cnt = 0; m_pre = 0; m_lvl = 0; m_neg = 0;
      end else if (m_pre == CDIV - 1) begin
        int t, sgn;
        sgn = (m_phase >= 32768) ? 1 : 0;
        t = target(m_phase, m_cnt, mod_idx);
        if (sgn) t = -t;
        if (t > m_lvl) m_lvl++;
        else if (t < m_lvl) m_lvl--;
        m_neg = sgn;
        m_phase = (m_phase + tune) % 65536;
        m_cnt = (m_cnt + 1) % TMAX;
        m_pre = 0;
      end else begin
        m_pre++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // observation statistics
  int max_lvl, min_lvl, overlap, nonzero, big_step;
  bit seen_zp, seen_zn, seen_p3;
  int prev_lvl;

  task automatic clear_stats();
    max_lvl = -9; min_lvl = 9; overlap = 0; nonzero = 0; big_step = 0;
  endtask

  task automatic run_cycles(input int n, input int settle);
    for (int i = 0; i < n; i++) begin
      int dl;
      @(negedge clk);
      dl = $signed(level_o);
      // per-cycle comparison: level (R3 R4 R5), gates (R6 R7 R8)
      check(dl == m_lvl, "R5 level vs model", dl, m_lvl);
      check(gate_o == m_gate, "R8 gates vs model", gate_o, m_gate);
      if (dl > max_lvl) max_lvl = dl;
      if (dl < min_lvl) min_lvl = dl;
      if (gate_o[7] && gate_o[8]) overlap++;
      if (i >= settle && dl != 0) nonzero++;
      if (dl - prev_lvl > 1 || prev_lvl - dl > 1) big_step++;
      if (gate_o == sw(1, 5, 8, 0)) seen_zp = 1;
      if (gate_o == sw(2, 5, 9, 0)) seen_zn = 1;
      if (gate_o == sw(3, 4, 6, 8)) seen_p3 = 1;
      prev_lvl = dl;
    end
  endtask

  initial begin
    prev_lvl = 0;
    clear_stats();
    repeat (4) @(negedge clk);
    check(gate_o == 9'd0, "R1 gates in reset", gate_o, 0);
    check(level_o == 4'd0, "R1 level in reset", level_o, 0);
    rst_n = 1;

    // full-scale modulation, one fundamental and more
    mod_idx = 8'd255; tune = 16'd40; en = 1;
    run_cycles(8000, 0);
    check(max_lvl == 4, "R2 positive peak", max_lvl, 4);
    check(min_lvl == -4, "R2 negative peak", min_lvl, -4);
    check(overlap == 0, "R9 S8 S9 overlap", overlap, 0);
    check(seen_zp, "R7 zero state positive half", seen_zp, 1);
    check(seen_zn, "R7 zero state negative half", seen_zn, 1);
    check(seen_p3, "R6 pattern for +3", seen_p3, 1);

    // reduced modulation index, about 0.6
    en = 0; @(negedge clk); en = 1;
    clear_stats();
    mod_idx = 8'd154;
    run_cycles(7000, 0);
    check(max_lvl == 3, "R3 peak at index 154", max_lvl, 3);
    check(overlap == 0, "R9 overlap at index 154", overlap, 0);

    // zero index: level settles at 0
    clear_stats();
    mod_idx = 8'd0;
    run_cycles(2000, 200);
    check(nonzero == 0, "R10 level with index 0", nonzero, 0);

    // fast reference: target jumps, level must creep one step per strobe
    clear_stats();
    mod_idx = 8'd255; tune = 16'd5000;
    run_cycles(4000, 0);
    check(big_step == 0, "R5 multi-step jumps", big_step, 0);

    // disable while active
    tune = 16'd40;
    run_cycles(600, 0);
    en = 0;
    @(negedge clk);
    check(gate_o == 9'd0, "R1 gates after disable", gate_o, 0);
    check(level_o == 4'd0, "R1 level after disable", level_o, 0);
    run_cycles(20, 0);
    en = 1;
    run_cycles(DEAD + 2, 0);
    check(gate_o == sw(1, 5, 8, 0), "R7 zero state after re-enable", gate_o, sw(1, 5, 8, 0));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule